// File: doc/BRIEF.md
# DMA channel address and count sequencer

This block is the address and count datapath of one DMA channel. A bus engine pulses a transfer strobe once per transfer. For each strobe, the block presents a 24-bit physical memory address in the same cycle. At the following clock edge it moves a 16-bit address counter, decrements a 16-bit transfer counter and handles terminal count. The register file supplies the configuration as plain inputs: the start address and count, an 8-bit page, a byte/word selector, an address direction and an auto-initialize flag. The register file also clears the channel mask and the sticky terminal-count flag.

The page is never modified. The address counter therefore wraps inside a 64 KB window in byte mode, or a 128 KB window in word mode, and never carries into the page. Word mode shifts the whole address left by one bit and drops page bit 0. The count register holds the number of transfers minus one. When auto-initialize is on, the channel reloads itself at terminal count. When it is off, the channel masks itself.

Top module: `xfer_addr_seq`

## Requirements
- R1: With `word_mode`=0, `mem_addr` equals {page[7:0], cur_addr[15:0]} in the same cycle.
- R2: With `word_mode`=1, `mem_addr` equals {page[7:1], cur_addr[15:0], 1'b0}: page bit 0 has no effect and address bit 0 is always 0.
- R3: With `addr_dec`=0, each accepted strobe adds 1 to `cur_addr`, and 0xFFFF wraps to 0x0000 with the page unchanged.
- R4: With `addr_dec`=1, each accepted strobe subtracts 1 from `cur_addr`, and 0x0000 wraps to 0xFFFF.
- R5: Each accepted strobe decrements `cur_count` by 1. `tc_pulse` is high during a strobe only when `cur_count` is 0x0000, and without auto-initialize the count then becomes 0xFFFF.
- R6: With `auto_init`=1, terminal count reloads `cur_addr` and `cur_count` from the values last loaded, and `chan_masked` stays 0.
- R7: With `auto_init`=0, terminal count sets `chan_masked` at the next edge. While `chan_masked`=1, strobes are ignored: address and count hold and `tc_pulse` stays 0. `unmask` clears the mask, but a terminal count in the same cycle wins.
- R8: `tc_flag` is set one edge after `tc_pulse` and stays set until `tc_clr`. A terminal count in the same cycle as `tc_clr` leaves it set.
- R9: `cfg_load` copies `cfg_addr` and `cfg_count` into both the base and current registers, and takes priority over a strobe or a reload in the same cycle.
- R10: After reset, `chan_masked`=1, `tc_flag`=0, and `cur_addr` and `cur_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_stb | input | 1 | One transfer this cycle |
| cfg_load | input | 1 | Load start address and count |
| cfg_addr | input | 16 | Start address value |
| cfg_count | input | 16 | Transfers minus one |
| page | input | 8 | Page bits above the counter |
| word_mode | input | 1 | 1 = 16-bit transfers |
| addr_dec | input | 1 | 1 = address counts down |
| auto_init | input | 1 | 1 = reload at terminal count |
| unmask | input | 1 | Clear the channel mask |
| tc_clr | input | 1 | Clear the sticky terminal-count flag |
| mem_addr | output | 24 | Physical address of the current transfer |
| tc_pulse | output | 1 | Terminal count, high with the final strobe |
| tc_flag | output | 1 | Sticky terminal-count status |
| chan_masked | output | 1 | Channel mask state |
| cur_addr | output | 16 | Current address counter |
| cur_count | output | 16 | Current count counter |

## Verification
`mem_addr` and `tc_pulse` are combinational. They are due in the same cycle as the strobe and the configuration that produce them. `cur_addr`, `cur_count`, `chan_masked` and `tc_flag` change at the first rising edge after the stimulus. The bench drives its inputs just after a falling edge and compares every output against its model one time unit later. At that point the combinational results reflect the new inputs, and the registered results reflect the previous edge. The model is then advanced exactly once per rising edge. Reset release passes through a two-stage synchronizer, so the bench keeps its inputs idle for several cycles after reset before it issues any command.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
  // Operation applied to a base/current counter pair this cycle.
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_STEP   = 2'd1,
    OP_RELOAD = 2'd2,
    OP_LOAD   = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/xseq_addr_ctr.sv
module xseq_addr_ctr
  import xseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op,
  input  logic          dec,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q, base_d, cur_q, cur_d;
  logic          base_en, cur_en;

  always_comb begin
    base_en = (op == OP_LOAD);
    base_d  = load_val;
    cur_en  = (op != OP_HOLD);
    unique case (op)
      OP_LOAD:   cur_d = load_val;
      OP_RELOAD: cur_d = base_q;
      OP_STEP:   cur_d = dec ? cur_q - 1'b1 : cur_q + 1'b1;
      default:   cur_d = cur_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  assign cur = cur_q;

  p_addr_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && !dec) |=> cur_q == $past(cur_q) + 1'b1);
  p_addr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && dec) |=> cur_q == $past(cur_q) - 1'b1);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(cur_q));
endmodule

// File: rtl/xseq_cnt_ctr.sv
module xseq_cnt_ctr
  import xseq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cur,
  output logic          at_zero
);
  logic [CW-1:0] base_q, cur_q, cur_d;
  logic          base_en, cur_en;

  always_comb begin
    base_en = (op == OP_LOAD);
    cur_en  = (op != OP_HOLD);
    unique case (op)
      OP_LOAD:   cur_d = load_val;
      OP_RELOAD: cur_d = base_q;
      OP_STEP:   cur_d = cur_q - 1'b1;
      default:   cur_d = cur_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_en) base_q <= load_val;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  assign cur     = cur_q;
  assign at_zero = (cur_q == '0);

  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && cur_q == '0) |=> cur_q == '1);
  p_cnt_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RELOAD) |=> cur_q == base_q);
  p_cnt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> cur_q == $past(load_val));
endmodule

// File: rtl/xseq_phys_map.sv
module xseq_phys_map #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic [PW-1:0]    page,
  input  logic [AW-1:0]    addr,
  input  logic             word_mode,
  output logic [PW+AW-1:0] phys
);
  always_comb begin
    if (word_mode) phys = {page[PW-1:1], addr, 1'b0};
    else           phys = {page, addr};
  end
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
  import xseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int CW = 16,
  localparam int PHW = PW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer_stb,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [PW-1:0]  page,
  input  logic           word_mode,
  input  logic           addr_dec,
  input  logic           auto_init,
  input  logic           unmask,
  input  logic           tc_clr,
  output logic [PHW-1:0] mem_addr,
  output logic           tc_pulse,
  output logic           tc_flag,
  output logic           chan_masked,
  output logic [AW-1:0]  cur_addr,
  output logic [CW-1:0]  cur_count
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic    accept, cnt_zero, tc_now;
  ctr_op_e op;
  logic    mask_q, mask_d, flag_q, flag_d;

  always_comb begin
    accept = xfer_stb && !mask_q;
    tc_now = accept && cnt_zero;
    if (cfg_load)              op = OP_LOAD;
    else if (tc_now && auto_init) op = OP_RELOAD;
    else if (accept)           op = OP_STEP;
    else                       op = OP_HOLD;
  end

  xseq_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .op(op), .dec(addr_dec),
    .load_val(cfg_addr), .cur(cur_addr)
  );

  xseq_cnt_ctr #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .op(op),
    .load_val(cfg_count), .cur(cur_count), .at_zero(cnt_zero)
  );

  xseq_phys_map #(.AW(AW), .PW(PW)) u_map (
    .page(page), .addr(cur_addr), .word_mode(word_mode), .phys(mem_addr)
  );

  // Mask and sticky status next state.
  always_comb begin
    mask_d = mask_q;
    if (tc_now && !auto_init) mask_d = 1'b1;
    else if (unmask)          mask_d = 1'b0;
    flag_d = flag_q;
    if (tc_now)      flag_d = 1'b1;
    else if (tc_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign tc_pulse    = tc_now;
  assign tc_flag     = flag_q;
  assign chan_masked = mask_q;

  p_mask_on_tc_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tc_pulse && !auto_init) |=> chan_masked);
  p_autoinit_open_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tc_pulse && auto_init && !chan_masked) |=> !chan_masked);
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    tc_pulse |=> tc_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tc_flag && !tc_clr) |=> tc_flag);
  p_word_lsb_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    word_mode |-> (mem_addr[0] == 1'b0));
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!word_mode && $stable(page) && $stable(word_mode))
      |-> mem_addr[PHW-1:AW] == page);
endmodule

// File: tb/xfer_addr_seq_test.sv
module xfer_addr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic xfer_stb, cfg_load, word_mode, addr_dec, auto_init, unmask, tc_clr;
  logic [15:0] cfg_addr, cfg_count;
  logic [7:0]  page;
  logic [23:0] mem_addr;
  logic tc_pulse, tc_flag, chan_masked;
  logic [15:0] cur_addr, cur_count;

  xfer_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb), .cfg_load(cfg_load),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .page(page),
    .word_mode(word_mode), .addr_dec(addr_dec), .auto_init(auto_init),
    .unmask(unmask), .tc_clr(tc_clr), .mem_addr(mem_addr),
    .tc_pulse(tc_pulse), .tc_flag(tc_flag), .chan_masked(chan_masked),
    .cur_addr(cur_addr), .cur_count(cur_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R10";
  // Reference state
  int m_a = 0, m_c = 0, m_ba = 0, m_bc = 0;
  bit m_mask = 1, m_flag = 0;

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_phys();
    if (word_mode) return ((int'(page) >> 1) << 17) | (m_a << 1);
    return (int'(page) << 16) | m_a;
  endfunction

  task automatic tick();
    bit acc, tc;
    #1;
    acc = xfer_stb && !m_mask;
    tc  = acc && (m_c == 0);
    chk(word_mode ? "R2 mem_addr" : "R1 mem_addr", int'(mem_addr), exp_phys());
    chk("R5 tc_pulse", int'(tc_pulse), int'(tc));
    chk("R3/R4 cur_addr", int'(cur_addr), m_a);
    chk("R5 cur_count", int'(cur_count), m_c);
    chk("R7 chan_masked", int'(chan_masked), int'(m_mask));
    chk("R8 tc_flag", int'(tc_flag), int'(m_flag));
    @(posedge clk);
    if (cfg_load) begin
      m_ba = cfg_addr; m_a = cfg_addr; m_bc = cfg_count; m_c = cfg_count;
    end else if (tc && auto_init) begin
      m_a = m_ba; m_c = m_bc;
    end else if (acc) begin
      m_a = (addr_dec ? m_a - 1 : m_a + 1) & 16'hFFFF;
      m_c = (m_c - 1) & 16'hFFFF;
    end
    if (tc && !auto_init) m_mask = 1;
    else if (unmask)      m_mask = 0;
    if (tc)          m_flag = 1;
    else if (tc_clr) m_flag = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    xfer_stb = 0; cfg_load = 0; unmask = 0; tc_clr = 0;
  endtask

  task automatic load(int a, int c);
    idle(); cfg_load = 1; cfg_addr = 16'(a); cfg_count = 16'(c); tick();
    idle(); unmask = 1; tick(); idle();
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      xfer_stb = 1; tick();
    end
    idle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; idle(); cfg_addr = 0; cfg_count = 0; page = 0;
    word_mode = 0; addr_dec = 0; auto_init = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10";
    repeat (4) tick();

    // Byte mode, increment across the 16-bit wrap, no auto-init.
    tag = "R3"; page = 8'h5A;
    load(16'hFFFE, 3);
    strobes(3);
    tag = "R5"; strobes(1);          // final transfer: terminal count
    tag = "R7"; strobes(3);          // masked: ignored
    tag = "R8"; tc_clr = 1; tick(); idle(); tick();

    // Word mode, odd page ignored, decrement, auto-init reload.
    tag = "R2"; page = 8'h5B; word_mode = 1; addr_dec = 1; auto_init = 1;
    load(16'h8001, 1);
    tag = "R6"; strobes(5);

    // Decrement wrap below zero.
    tag = "R4"; auto_init = 0;
    load(16'h0000, 16'h0010);
    strobes(2);

    // Load wins over a strobe in the same cycle.
    tag = "R9"; xfer_stb = 1; cfg_load = 1; cfg_addr = 16'h1234; cfg_count = 0;
    tick(); idle();
    // Terminal count and clear of the flag together; unmask in same cycle.
    tag = "R8"; xfer_stb = 1; tc_clr = 1; unmask = 1; tick(); idle();
    tag = "R7"; tick();

    // Mixed stimulus.
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      xfer_stb  = ($urandom % 4) != 0;
      cfg_load  = ($urandom % 23) == 0;
      cfg_addr  = 16'($urandom);
      cfg_count = 16'($urandom % 6);
      unmask    = ($urandom % 5) == 0;
      tc_clr    = ($urandom % 7) == 0;
      if (($urandom % 31) == 0) begin
        page = 8'($urandom); word_mode = 1'($urandom);
        addr_dec = 1'($urandom); auto_init = 1'($urandom);
      end
      tick();
    end
    idle(); tick();
    finish_run();
  end
endmodule